// File: doc/BRIEF.md
# Tightly-Coupled Memory Enable Router

This block owns the enable state of two tightly-coupled memory windows, one for instruction storage and one for data storage, and decides for each core access whether it is served by the local SRAM or sent to the external system bus. An address inside a window whose enable is set selects that SRAM; an address in a disabled window, or outside both windows, selects the bus. Routing is purely combinational on the request address and the current enable bits.

The two enable bits are loaded together from an init-memory input on every clock edge while the synchronous reset is held, so the value present on the last reset edge decides whether the core leaves reset with both windows active (warm boot from preserved memory contents) or with both inactive (cold boot from the bus). Once reset is released that input is ignored. Software then changes either bit, or both, by writing the control register at index 1, and reads the bits back through the same register port. A high-vector input picks the reset fetch address: the top of the address space when high, address zero (the base of the instruction window) when low, so a cold boot with memory enabled can be steered away from SRAM that holds nothing yet.

Top module: `tcm_enable_router`

## Requirements
- R1: On every clock edge with `rst_n` low and `init_mem_i` low, both enables are cleared; after release, register reads show bits 1 and 0 as zero and accesses to both windows select the bus.
- R2: On every clock edge with `rst_n` low and `init_mem_i` high, both enables are set; after release, accesses inside either window select that window's SRAM.
- R3: Once `rst_n` is high, changes on `init_mem_i` leave both enables unchanged until the next reset.
- R4: While a window's enable is clear, an access to any address in that window selects the bus and never that SRAM.
- R5: With default parameters the instruction window covers 0x00000000 to 0x00007FFF and the data window covers 0x00400000 to 0x00407FFF; an access inside an enabled window asserts only that window's select, any other valid access asserts only `sel_bus_o`, and with `req_valid_i` low all three selects are low.
- R6: A write (`cfg_we_i` high) with `cfg_idx_i` equal to 1 loads the data enable from `cfg_wdata_i` bit 0 and the instruction enable from bit 1 in the same write; a write to any other index changes neither enable.
- R7: A register write changes routing from the cycle after the write cycle; an access presented in the write cycle itself is routed with the old enables.
- R8: `cfg_rdata_o` returns the instruction enable at bit 1 and the data enable at bit 0, all other bits zero, when `cfg_idx_i` is 1, and returns zero for every other index.
- R9: `boot_vec_o` is 0xFFFF0000 while `hivec_i` is high and 0x00000000 while it is low.
- R10: An access at the low boot vector 0x00000000 selects the instruction SRAM when its enable is set and the bus when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| init_mem_i | input | 1 | Enable value loaded into both windows while reset is held |
| hivec_i | input | 1 | Selects the high reset fetch address |
| req_valid_i | input | 1 | Core access present this cycle |
| req_addr_i | input | 32 | Core access address |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 4 | Register index for write and read |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_idx_i` |
| boot_vec_o | output | 32 | Reset fetch address |
| sel_itcm_o | output | 1 | Access goes to the instruction SRAM |
| sel_dtcm_o | output | 1 | Access goes to the data SRAM |
| sel_bus_o | output | 1 | Access goes to the external bus |

## Verification
Routing is tried under all four enable combinations, reached both through reset with each init-memory level and through register writes of each bit pattern, so a swapped bit position or a shared enable shows up as the wrong select. Addresses are placed at the first and last word of each window and one word past each end, which separates a correct size compare from an off-by-one or a wrong window base. A write is paired with an access in the same cycle and the next, telling a write that takes effect too early from one that lands on time, and a write to a different index tells a loose index decode from a correct one. The init-memory input is flipped on the edge reset releases and later, which shows whether it is sampled only while reset is held.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   // control register holding the two window enables
   localparam int unsigned CTRL_IDX = 1;
   // bit positions of the enables in that register
   localparam int unsigned DEN_BIT  = 0;
   localparam int unsigned IEN_BIT  = 1;
   // number of windows handled
   localparam int unsigned N_WIN    = 2;
   localparam int unsigned WIN_INSTR = 0;
   localparam int unsigned WIN_DATA  = 1;

   typedef struct packed {
      logic ien;
      logic den;
   } tcm_en_t;
endpackage

// File: rtl/tcm_window_decode.sv
module tcm_window_decode #(
   parameter int unsigned          ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]    BASE      = '0,
   parameter int unsigned          SIZE_LOG2 = 15
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   generate
      if (SIZE_LOG2 >= ADDR_W) begin : g_full
         assign hit_o = 1'b1;
      end else begin : g_cmp
         localparam int unsigned TAG_W = ADDR_W - SIZE_LOG2;
         localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SIZE_LOG2];
         assign hit_o = (addr_i[ADDR_W-1:SIZE_LOG2] == BASE_TAG);
      end
   endgenerate
endmodule

// File: rtl/tcm_ctrl_reg.sv
module tcm_ctrl_reg
   import tcm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_mem_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output tcm_en_t           en_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(CTRL_IDX);

   tcm_en_t en_q;
   logic    wr_hit;
   logic    unused_wdata;

   assign wr_hit       = we_i && (idx_i == SEL_IDX);
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q.ien <= init_mem_i;
         en_q.den <= init_mem_i;
      end else if (wr_hit) begin
         en_q.ien <= wdata_i[IEN_BIT];
         en_q.den <= wdata_i[DEN_BIT];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (idx_i == SEL_IDX) begin
         rdata_o[IEN_BIT] = en_q.ien;
         rdata_o[DEN_BIT] = en_q.den;
      end
   end

   assign en_o = en_q;
endmodule

// File: rtl/tcm_enable_router.sv
module tcm_enable_router
   import tcm_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       IDX_W      = 4,
   parameter logic [ADDR_W-1:0] ITCM_BASE  = 32'h0000_0000,
   parameter int unsigned       ITCM_LOG2  = 15,
   parameter logic [ADDR_W-1:0] DTCM_BASE  = 32'h0040_0000,
   parameter int unsigned       DTCM_LOG2  = 15,
   parameter logic [ADDR_W-1:0] HIVEC_ADDR = 32'hFFFF_0000,
   parameter logic [ADDR_W-1:0] LOVEC_ADDR = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_mem_i,
   input  logic              hivec_i,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              cfg_we_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [DATA_W-1:0] cfg_rdata_o,
   output logic [ADDR_W-1:0] boot_vec_o,
   output logic              sel_itcm_o,
   output logic              sel_dtcm_o,
   output logic              sel_bus_o
);
   localparam int unsigned MAX_LOG2 = (ITCM_LOG2 > DTCM_LOG2) ? ITCM_LOG2 : DTCM_LOG2;
   localparam int unsigned IDX_MAX  = (1 << IDX_W) - 1;

   // elaboration-time parameter checks
   generate
      if (ITCM_LOG2 >= ADDR_W || DTCM_LOG2 >= ADDR_W) begin : g_err_size
         $error("window size must be smaller than the address space");
      end
      if (DATA_W <= IEN_BIT || DATA_W <= DEN_BIT) begin : g_err_dw
         $error("register data too narrow for enable bits");
      end
      if (IDX_MAX < CTRL_IDX) begin : g_err_idx
         $error("register index too narrow");
      end
      if ((ITCM_BASE >> ITCM_LOG2) << ITCM_LOG2 != ITCM_BASE) begin : g_err_ialign
         $error("instruction window base not aligned to its size");
      end
      if ((DTCM_BASE >> DTCM_LOG2) << DTCM_LOG2 != DTCM_BASE) begin : g_err_dalign
         $error("data window base not aligned to its size");
      end
      if ((ITCM_BASE >> MAX_LOG2) == (DTCM_BASE >> MAX_LOG2)) begin : g_err_overlap
         $error("instruction and data windows overlap");
      end
      if ((HIVEC_ADDR >> ITCM_LOG2) == (ITCM_BASE >> ITCM_LOG2) ||
          (HIVEC_ADDR >> DTCM_LOG2) == (DTCM_BASE >> DTCM_LOG2)) begin : g_err_hivec
         $error("high boot vector must lie in bus space");
      end
   endgenerate

   tcm_en_t           en_s;
   logic              ien_s;
   logic              den_s;
   logic [N_WIN-1:0]  win_hit;
   logic              go_itcm;
   logic              go_dtcm;

   tcm_ctrl_reg #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_mem_i (init_mem_i),
      .we_i       (cfg_we_i),
      .idx_i      (cfg_idx_i),
      .wdata_i    (cfg_wdata_i),
      .en_o       (en_s),
      .rdata_o    (cfg_rdata_o)
   );

   for (genvar g = 0; g < N_WIN; g++) begin : g_win
      localparam logic [ADDR_W-1:0] W_BASE = (g == WIN_INSTR) ? ITCM_BASE : DTCM_BASE;
      localparam int unsigned       W_LOG2 = (g == WIN_INSTR) ? ITCM_LOG2 : DTCM_LOG2;
      tcm_window_decode #(
         .ADDR_W    (ADDR_W),
         .BASE      (W_BASE),
         .SIZE_LOG2 (W_LOG2)
      ) u_dec (
         .addr_i (req_addr_i),
         .hit_o  (win_hit[g])
      );
   end

   assign ien_s   = en_s.ien;
   assign den_s   = en_s.den;
   assign go_itcm = win_hit[WIN_INSTR] && ien_s;
   assign go_dtcm = win_hit[WIN_DATA]  && den_s && !go_itcm;

   assign sel_itcm_o = req_valid_i && go_itcm;
   assign sel_dtcm_o = req_valid_i && go_dtcm;
   assign sel_bus_o  = req_valid_i && !go_itcm && !go_dtcm;

   assign boot_vec_o = hivec_i ? HIVEC_ADDR : LOVEC_ADDR;
endmodule

// File: rtl/tcm_enable_router_chk.sv
module tcm_enable_router_chk
   import tcm_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       IDX_W      = 4,
   parameter logic [ADDR_W-1:0] HIVEC_ADDR = 32'hFFFF_0000,
   parameter logic [ADDR_W-1:0] LOVEC_ADDR = 32'h0000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_mem_i,
   input logic              hivec_i,
   input logic              req_valid_i,
   input logic              cfg_we_i,
   input logic [IDX_W-1:0]  cfg_idx_i,
   input logic [DATA_W-1:0] cfg_wdata_i,
   input logic [ADDR_W-1:0] boot_vec_o,
   input logic              sel_itcm_o,
   input logic              sel_dtcm_o,
   input logic              sel_bus_o,
   input logic              ien,
   input logic              den
);
   logic past_v = 1'b0;
   logic wr_hit;

   always_ff @(posedge clk) past_v <= 1'b1;
   assign wr_hit = cfg_we_i && (cfg_idx_i == IDX_W'(CTRL_IDX));

   // R1 R2: enables leave reset equal to the init pin on the last reset edge
   a_r2_reset_follows_init: assert property (@(posedge clk) disable iff (!rst_n)
      (past_v && !$past(rst_n)) |-> (ien == $past(init_mem_i) && den == $past(init_mem_i)));

   // R3: with no control write, enables hold whatever init_mem_i does
   a_r3_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_v && $past(rst_n) && !$past(wr_hit)) |-> $stable({ien, den}));

   // R6: control write loads both enables from their bits
   a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (past_v && $past(rst_n) && $past(wr_hit)) |->
      (ien == $past(cfg_wdata_i[IEN_BIT]) && den == $past(cfg_wdata_i[DEN_BIT])));

   // R4: a disabled window is never selected
   a_r4_itcm_off_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> !sel_itcm_o);
   a_r4_dtcm_off_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !den |-> !sel_dtcm_o);

   // R5: one select per valid access, none when idle
   a_r5_onehot_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |-> $onehot({sel_itcm_o, sel_dtcm_o, sel_bus_o}));
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |-> ({sel_itcm_o, sel_dtcm_o, sel_bus_o} == 3'b000));

   // R9: boot vector follows the high-vector input
   a_r9_boot_vector: assert property (@(posedge clk) disable iff (!rst_n)
      boot_vec_o == (hivec_i ? HIVEC_ADDR : LOVEC_ADDR));
endmodule

bind tcm_enable_router tcm_enable_router_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .IDX_W      (IDX_W),
   .HIVEC_ADDR (HIVEC_ADDR),
   .LOVEC_ADDR (LOVEC_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .init_mem_i  (init_mem_i),
   .hivec_i     (hivec_i),
   .req_valid_i (req_valid_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_idx_i   (cfg_idx_i),
   .cfg_wdata_i (cfg_wdata_i),
   .boot_vec_o  (boot_vec_o),
   .sel_itcm_o  (sel_itcm_o),
   .sel_dtcm_o  (sel_dtcm_o),
   .sel_bus_o   (sel_bus_o),
   .ien         (ien_s),
   .den         (den_s)
);

// File: tb/tb_tcm_enable_router.sv
`timescale 1ns/1ps
module tb_tcm_enable_router;
   localparam logic [31:0] I_BASE = 32'h0000_0000;
   localparam logic [31:0] D_BASE = 32'h0040_0000;
   localparam logic [31:0] WSIZE  = 32'h0000_8000;
   localparam logic [31:0] HI_VEC = 32'hFFFF_0000;
   localparam int RT_NONE = 0, RT_I = 1, RT_D = 2, RT_BUS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_mem = 1'b0;
   logic        hivec = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = 4'd1;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] boot_vec;
   logic        sel_i, sel_d, sel_b;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;
   bit m_ien, m_den;

   always #2 clk = ~clk;

   tcm_enable_router #(
      .ITCM_BASE (I_BASE), .ITCM_LOG2 (15),
      .DTCM_BASE (D_BASE), .DTCM_LOG2 (15)
   ) dut (
      .clk (clk), .rst_n (rst_n), .init_mem_i (init_mem), .hivec_i (hivec),
      .req_valid_i (req_valid), .req_addr_i (req_addr),
      .cfg_we_i (cfg_we), .cfg_idx_i (cfg_idx), .cfg_wdata_i (cfg_wdata),
      .cfg_rdata_o (cfg_rdata), .boot_vec_o (boot_vec),
      .sel_itcm_o (sel_i), .sel_dtcm_o (sel_d), .sel_bus_o (sel_b)
   );

   // behavioural reference of the enable state
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ien <= init_mem;
         m_den <= init_mem;
      end else if (cfg_we && cfg_idx == 4'd1) begin
         m_ien <= cfg_wdata[1];
         m_den <= cfg_wdata[0];
      end
   end

   function automatic int ref_route(bit v, logic [31:0] a);
      if (!v) return RT_NONE;
      if (m_ien && a >= I_BASE && a < I_BASE + WSIZE) return RT_I;
      if (m_den && a >= D_BASE && a < D_BASE + WSIZE) return RT_D;
      return RT_BUS;
   endfunction

   function automatic int dut_route();
      case ({sel_i, sel_d, sel_b})
         3'b000:  return RT_NONE;
         3'b100:  return RT_I;
         3'b010:  return RT_D;
         3'b001:  return RT_BUS;
         default: return 9;
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the reference, between edges
   always begin
      @(negedge clk);
      #1;
      if (cmp_on && rst_n) begin
         chk(dut_route() == ref_route(req_valid, req_addr), "R5 route", dut_route(),
             ref_route(req_valid, req_addr));
         chk(cfg_rdata == ((cfg_idx == 4'd1) ? {30'd0, m_ien, m_den} : 32'd0),
             "R8 rdata", cfg_rdata, (cfg_idx == 4'd1) ? {30'd0, m_ien, m_den} : 32'd0);
         chk(boot_vec == (hivec ? HI_VEC : 32'd0), "R9 vector", boot_vec,
             hivec ? HI_VEC : 32'd0);
      end
   end

   task automatic step(bit v, logic [31:0] a, bit we, logic [3:0] idx, logic [31:0] wd);
      @(negedge clk);
      req_valid = v; req_addr = a; cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
      #1;
   endtask

   task automatic access(logic [31:0] a, int exp, string tag);
      step(1'b1, a, 1'b0, 4'd1, '0);
      chk(dut_route() == exp, tag, dut_route(), exp);
   endtask

   // reset: init held at 'during', changed to 'last' on final reset edge,
   // then inverted as reset releases
   task automatic do_reset(bit during, bit last);
      @(negedge clk);
      rst_n = 1'b0; init_mem = during; req_valid = 1'b0; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      init_mem = last;
      @(negedge clk);
      rst_n = 1'b1; init_mem = ~last; cfg_idx = 4'd1;
      #1;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset(1'b0, 1'b0);
      cmp_on = 1;
      // R1: cold reset, both off
      chk(cfg_rdata == 32'd0, "R1 rdata after reset", cfg_rdata, 0);
      access(32'h0000_0100, RT_BUS, "R1 instr window");
      access(D_BASE + 32'h10, RT_BUS, "R1 data window");
      // R10: low vector with instr off goes to bus
      access(32'h0000_0000, RT_BUS, "R10 low vector bus");
      // R3: init pin toggles after release
      @(negedge clk); init_mem = 1'b1;
      repeat (3) step(1'b0, '0, 1'b0, 4'd1, '0);
      chk(cfg_rdata == 32'd0, "R3 init ignored", cfg_rdata, 0);
      init_mem = 1'b0;
      // R7: write instr-only; same-cycle access uses old state
      step(1'b1, 32'h0000_0100, 1'b1, 4'd1, 32'h0000_0002);
      chk(dut_route() == RT_BUS, "R7 write cycle old route", dut_route(), RT_BUS);
      access(32'h0000_0100, RT_I, "R7 next cycle new route");
      chk(cfg_rdata == 32'd2, "R6 instr-only write", cfg_rdata, 2);
      access(D_BASE, RT_BUS, "R4 data off");
      // R6: write to another index ignored
      step(1'b0, '0, 1'b1, 4'd2, 32'h0000_0003);
      step(1'b0, '0, 1'b0, 4'd1, '0);
      chk(cfg_rdata == 32'd2, "R6 other index ignored", cfg_rdata, 2);
      // R8: read other index
      step(1'b0, '0, 1'b0, 4'd0, '0);
      chk(cfg_rdata == 32'd0, "R8 other index reads zero", cfg_rdata, 0);
      // R5: both on, window edges
      step(1'b0, '0, 1'b1, 4'd1, 32'hFFFF_FFFF);
      step(1'b0, '0, 1'b0, 4'd1, '0);
      chk(cfg_rdata == 32'd3, "R8 both bits only", cfg_rdata, 3);
      access(I_BASE + WSIZE - 4, RT_I, "R5 instr last word");
      access(I_BASE + WSIZE, RT_BUS, "R5 past instr window");
      access(D_BASE, RT_D, "R5 data first word");
      access(D_BASE + WSIZE - 1, RT_D, "R5 data last byte");
      access(D_BASE + WSIZE, RT_BUS, "R5 past data window");
      access(D_BASE - 1, RT_BUS, "R5 below data window");
      step(1'b0, D_BASE, 1'b0, 4'd1, '0);
      chk(dut_route() == RT_NONE, "R5 idle no select", dut_route(), RT_NONE);
      // R9: vector selection
      @(negedge clk); hivec = 1'b1; #1;
      chk(boot_vec == HI_VEC, "R9 high vector", boot_vec, HI_VEC);
      access(HI_VEC, RT_BUS, "R9 high vector in bus space");
      @(negedge clk); hivec = 1'b0; #1;
      chk(boot_vec == 32'd0, "R9 low vector", boot_vec, 0);
      // R2: warm reset with init high
      do_reset(1'b1, 1'b1);
      chk(cfg_rdata == 32'd3, "R2 both on after reset", cfg_rdata, 3);
      access(32'h0000_0000, RT_I, "R10 low vector to instr SRAM");
      access(D_BASE + 32'h40, RT_D, "R2 data window");
      // R4: disable instr only via write (data bit 0 set)
      step(1'b0, '0, 1'b1, 4'd1, 32'h0000_0001);
      access(32'h0000_0200, RT_BUS, "R4 instr off to bus");
      access(D_BASE + 32'h40, RT_D, "R6 data kept on");
      // R1 R3: init high through reset, low only on last edge
      do_reset(1'b1, 1'b0);
      chk(cfg_rdata == 32'd0, "R1 last reset edge wins", cfg_rdata, 0);
      repeat (2) step(1'b0, '0, 1'b0, 4'd1, '0);
      chk(cfg_rdata == 32'd0, "R3 high after release ignored", cfg_rdata, 0);
      access(32'h0000_0000, RT_BUS, "R10 low vector bus after cold reset");
      repeat (2) step(1'b0, '0, 1'b0, 4'd1, '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule